// File: doc/BRIEF.md
# Instruction Address Sequencer with Circular Return Stack

This block produces the fetch address for a small 8-bit controller core. It holds a 13-bit program counter, a 5-bit latch that supplies the upper address bits for jumps, and an 8-entry return stack. Once per instruction cycle, the core's decoder issues one command on a 3-bit port. The command tells the sequencer to do one of the following: hold, step forward, take a computed jump through the low address byte, jump to an opcode target, call, return, or vector to the interrupt address.

The upper bits of the new address come from the latch, and which latch bits are used depends on the command. A computed jump takes all five latch bits. An opcode jump or call keeps its eleven target bits and takes only the top two latch bits. The stack is a ring: it has no overflow or underflow indication, so extra pushes overwrite the oldest entries and extra pops return stale entries. Software can read the low address byte and the latch. It cannot see the stack pointer.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fetch_addr`, `pcl_rd` and `lat_q` read 0.
- R2: Command 1 (step) makes `fetch_addr` one higher after the clock edge, and 0x1FFF steps to 0x0000.
- R3: Command 2 (computed jump) loads `fetch_addr` with {`lat_q`[4:0], `alu_data`[7:0]}.
- R4: Command 3 (jump) loads `fetch_addr` with {`lat_q`[4:3], `jmp_tgt`[10:0]}.
- R5: Command 4 (call) loads the same address as R4 and pushes the current address plus one.
- R6: Command 5 (return) loads `fetch_addr` from the most recently pushed entry that has not yet been popped.
- R7: Command 6 (interrupt) loads `fetch_addr` with 0x004 and pushes the current address unchanged.
- R8: The stack holds 8 entries in a ring, so a ninth push overwrites the value of the first push, a tenth push overwrites the second, and so on.
- R9: A pop beyond the pushed depth steps the pointer back modulo 8 and returns whatever that slot holds, with no indication.
- R10: `lat_q` changes only on a cycle with `lat_we` high, where it takes `lat_wdata`. Pushes and pops never alter it. A jump in the same cycle as a latch write uses the latch value from before the write.
- R11: Command 0 (hold) and command 7 leave both `fetch_addr` and the stack unchanged.
- R12: `pcl_rd` always equals `fetch_addr`[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Sequencing command for this cycle (encodings in R2 to R11) |
| alu_data | input | 8 | Result written to the low address byte on a computed jump |
| jmp_tgt | input | 11 | Target field of a jump or call opcode |
| lat_we | input | 1 | Write strobe for the upper-address latch |
| lat_wdata | input | 5 | New latch value |
| fetch_addr | output | 13 | Registered current fetch address |
| pcl_rd | output | 8 | Read image of the low address byte |
| lat_q | output | 5 | Current latch value |

## Verification
A corrupted program counter shows on `fetch_addr` at the first clock edge after the faulty command. A wrong latch source range shows only when a jump carries nonzero high latch bits. A fault in the stack pointer or the stack contents stays hidden until a return is issued, and it then shows as a wrong address. Because of this, the bench overfills the ring and over-pops it, so that slot reuse and pointer wrap each reach the port.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    CMD_HOLD = 3'd0,
    CMD_STEP = 3'd1,
    CMD_CJMP = 3'd2,
    CMD_JUMP = 3'd3,
    CMD_CALL = 3'd4,
    CMD_RET  = 3'd5,
    CMD_INTR = 3'd6,
    CMD_RSVD = 3'd7
  } seq_cmd_e;
endpackage

// File: rtl/pcseq_ring_stack.sv
// Circular return stack; DEPTH must be a power of two so the pointer wraps naturally.
module pcseq_ring_stack #(
  parameter int WIDTH = 13,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PTR_W-1:0] top_q;
  logic [PTR_W-1:0] prev_idx;

  assign prev_idx = top_q - PTR_W'(1);
  assign rdata    = slots[prev_idx];

  // Contents are not reset, so the array maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push) slots[top_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       top_q <= '0;
    else if (push) top_q <= top_q + PTR_W'(1);
    else if (pop)  top_q <= prev_idx;
  end
endmodule

// File: rtl/pcseq_hi_latch.sv
module pcseq_hi_latch #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/pcseq_next_addr.sv
module pcseq_next_addr
  import pcseq_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int LO_W     = 8,
  parameter int TGT_W    = 11,
  parameter int VEC_ADDR = 4
) (
  input  seq_cmd_e               cmd,
  input  logic [PC_W-1:0]        pc,
  input  logic [PC_W-LO_W-1:0]   lat,
  input  logic [LO_W-1:0]        alu_data,
  input  logic [TGT_W-1:0]       jmp_tgt,
  input  logic [PC_W-1:0]        pop_data,
  output logic [PC_W-1:0]        pc_nxt,
  output logic                   push,
  output logic                   pop,
  output logic [PC_W-1:0]        push_data
);
  localparam int LAT_W  = PC_W - LO_W;
  localparam int JHI_W  = PC_W - TGT_W;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] jump_addr;
  logic [PC_W-1:0] cjmp_addr;

  assign pc_inc    = pc + PC_W'(1);
  assign jump_addr = {lat[LAT_W-1 -: JHI_W], jmp_tgt};
  assign cjmp_addr = {lat, alu_data};

  always_comb begin
    pc_nxt    = pc;
    push      = 1'b0;
    pop       = 1'b0;
    push_data = pc_inc;
    unique case (cmd)
      CMD_STEP: pc_nxt = pc_inc;
      CMD_CJMP: pc_nxt = cjmp_addr;
      CMD_JUMP: pc_nxt = jump_addr;
      CMD_CALL: begin
        pc_nxt = jump_addr;
        push   = 1'b1;
      end
      CMD_RET: begin
        pc_nxt = pop_data;
        pop    = 1'b1;
      end
      CMD_INTR: begin
        pc_nxt    = PC_W'(VEC_ADDR);
        push      = 1'b1;
        push_data = pc;
      end
      default: pc_nxt = pc;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcseq_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int LO_W     = 8,
  parameter int TGT_W    = 11,
  parameter int DEPTH    = 8,
  parameter int VEC_ADDR = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2:0]            cmd,
  input  logic [LO_W-1:0]       alu_data,
  input  logic [TGT_W-1:0]      jmp_tgt,
  input  logic                  lat_we,
  input  logic [PC_W-LO_W-1:0]  lat_wdata,
  output logic [PC_W-1:0]       fetch_addr,
  output logic [LO_W-1:0]       pcl_rd,
  output logic [PC_W-LO_W-1:0]  lat_q
);
  localparam int LAT_W = PC_W - LO_W;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] stk_rdata;
  logic [PC_W-1:0] stk_wdata;
  logic            stk_push;
  logic            stk_pop;
  seq_cmd_e        cmd_e;

  assign cmd_e = seq_cmd_e'(cmd);

  pcseq_hi_latch #(.WIDTH(LAT_W)) hi_latch_i (
    .clk   (clk),
    .rst   (rst),
    .we    (lat_we),
    .wdata (lat_wdata),
    .q     (lat_q)
  );

  pcseq_next_addr #(
    .PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W), .VEC_ADDR(VEC_ADDR)
  ) next_addr_i (
    .cmd       (cmd_e),
    .pc        (pc_q),
    .lat       (lat_q),
    .alu_data  (alu_data),
    .jmp_tgt   (jmp_tgt),
    .pop_data  (stk_rdata),
    .pc_nxt    (pc_nxt),
    .push      (stk_push),
    .pop       (stk_pop),
    .push_data (stk_wdata)
  );

  pcseq_ring_stack #(.WIDTH(PC_W), .DEPTH(DEPTH)) ring_stack_i (
    .clk   (clk),
    .rst   (rst),
    .push  (stk_push),
    .pop   (stk_pop),
    .wdata (stk_wdata),
    .rdata (stk_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign fetch_addr = pc_q;
  assign pcl_rd     = pc_q[LO_W-1:0];
endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk #(
  parameter int PC_W     = 13,
  parameter int LO_W     = 8,
  parameter int TGT_W    = 11,
  parameter int VEC_ADDR = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           cmd,
  input logic [LO_W-1:0]      alu_data,
  input logic [TGT_W-1:0]     jmp_tgt,
  input logic                 lat_we,
  input logic [PC_W-LO_W-1:0] lat_wdata,
  input logic [PC_W-1:0]      fetch_addr,
  input logic [LO_W-1:0]      pcl_rd,
  input logic [PC_W-LO_W-1:0] lat_q
);
  localparam int LAT_W = PC_W - LO_W;
  localparam int JHI_W = PC_W - TGT_W;

  logic rst_seen_q = 1'b0;
  always_ff @(posedge clk) rst_seen_q <= rst;

  // R1: the cycle after a reset cycle shows a cleared address and latch
  always_ff @(posedge clk) begin
    if (rst_seen_q) begin
      a_r1_reset_clear: assert (fetch_addr == '0 && lat_q == '0);
    end
  end

  a_r2_step_inc: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd1 |=> fetch_addr == PC_W'($past(fetch_addr) + PC_W'(1)));

  a_r3_cjmp_src: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd2 |=> fetch_addr == {$past(lat_q), $past(alu_data)});

  a_r4_jump_src: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd3 || cmd == 3'd4) |=>
      fetch_addr == {$past(lat_q[LAT_W-1 -: JHI_W]), $past(jmp_tgt)});

  a_r7_vector: assert property (@(posedge clk) disable iff (rst)
    cmd == 3'd6 |=> fetch_addr == PC_W'(VEC_ADDR));

  a_r10_latch_hold: assert property (@(posedge clk) disable iff (rst)
    !lat_we |=> $stable(lat_q));

  a_r10_latch_load: assert property (@(posedge clk) disable iff (rst)
    lat_we |=> lat_q == $past(lat_wdata));

  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd == 3'd0 || cmd == 3'd7) |=> $stable(fetch_addr));

  a_r12_low_image: assert property (@(posedge clk) disable iff (rst)
    pcl_rd == fetch_addr[LO_W-1:0]);
endmodule

bind pc_sequencer pcseq_chk #(
  .PC_W(PC_W), .LO_W(LO_W), .TGT_W(TGT_W), .VEC_ADDR(VEC_ADDR)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cmd        (cmd),
  .alu_data   (alu_data),
  .jmp_tgt    (jmp_tgt),
  .lat_we     (lat_we),
  .lat_wdata  (lat_wdata),
  .fetch_addr (fetch_addr),
  .pcl_rd     (pcl_rd),
  .lat_q      (lat_q)
);

// File: tb/pc_sequencer_tb.sv
`timescale 1ns/1ps
module pc_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [7:0]  alu_data = '0;
  logic [10:0] jmp_tgt = '0;
  logic        lat_we = 1'b0;
  logic [4:0]  lat_wdata = '0;
  logic [12:0] fetch_addr;
  logic [7:0]  pcl_rd;
  logic [4:0]  lat_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [12:0] m_pc;
  logic [4:0]  m_lat;
  logic [12:0] m_stk [8];
  logic [2:0]  m_sp;

  always #2.5 clk = ~clk;

  pc_sequencer dut_i (
    .clk(clk), .rst(rst), .cmd(cmd), .alu_data(alu_data), .jmp_tgt(jmp_tgt),
    .lat_we(lat_we), .lat_wdata(lat_wdata), .fetch_addr(fetch_addr),
    .pcl_rd(pcl_rd), .lat_q(lat_q)
  );

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      3'd6: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [12:0] exp_next(input logic [2:0] c, input logic [12:0] pc,
                                           input logic [4:0] lat, input logic [7:0] a,
                                           input logic [10:0] t, input logic [12:0] top);
    case (c)
      3'd1:      return pc + 13'd1;
      3'd2:      return {lat, a};
      3'd3, 3'd4: return {lat[4:3], t};
      3'd5:      return top;
      3'd6:      return 13'h004;
      default:   return pc;
    endcase
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives inputs, crosses one rising edge, checks at the next falling edge.
  task automatic step(input logic [2:0] c, input logic [7:0] a, input logic [10:0] t,
                      input logic we, input logic [4:0] wd, input string tag);
    logic [12:0] nxt;
    cmd = c; alu_data = a; jmp_tgt = t; lat_we = we; lat_wdata = wd;
    @(posedge clk);
    nxt = exp_next(c, m_pc, m_lat, a, t, m_stk[m_sp - 3'd1]);
    if (c == 3'd4) begin m_stk[m_sp] = m_pc + 13'd1; m_sp = m_sp + 3'd1; end
    else if (c == 3'd6) begin m_stk[m_sp] = m_pc; m_sp = m_sp + 3'd1; end
    else if (c == 3'd5) m_sp = m_sp - 3'd1;
    m_pc = nxt;
    if (we) m_lat = wd;
    @(negedge clk);
    check((tag == "") ? tag_of(c) : tag, fetch_addr, m_pc);
    check("R10", {8'd0, lat_q}, {8'd0, m_lat});
    check("R12", {5'd0, pcl_rd}, {5'd0, m_pc[7:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    m_pc = '0; m_lat = '0; m_sp = '0;
    for (int i = 0; i < 8; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    check("R1", fetch_addr, 13'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", fetch_addr, 13'd0);
    check("R1", {8'd0, lat_q}, 13'd0);
    check("R1", {5'd0, pcl_rd}, 13'd0);

    // R2 stepping, then the wrap at the top of the address space
    step(3'd1, 8'h00, 11'h0, 1'b0, 5'h00, "R2");
    step(3'd1, 8'h00, 11'h0, 1'b1, 5'h1F, "R2");
    step(3'd2, 8'hFF, 11'h0, 1'b0, 5'h00, "R3");
    step(3'd1, 8'h00, 11'h0, 1'b0, 5'h00, "R2");
    // R10 latch written in the same cycle as a jump: old value supplies the top bits
    step(3'd3, 8'h00, 11'h2AB, 1'b1, 5'h15, "R10");
    step(3'd3, 8'h00, 11'h155, 1'b0, 5'h00, "R4");
    step(3'd2, 8'h3C, 11'h0, 1'b0, 5'h00, "R3");
    step(3'd0, 8'h11, 11'h7FF, 1'b0, 5'h00, "R11");
    step(3'd7, 8'h22, 11'h3FF, 1'b0, 5'h00, "R11");

    // R8 ten calls overfill the ring, R9 the ninth return wraps to a reused slot
    for (int i = 0; i < 10; i++) step(3'd4, 8'h00, 11'(16 * i + 3), 1'b0, 5'h00, "R8");
    for (int i = 0; i < 8; i++) step(3'd5, 8'h00, 11'h0, 1'b0, 5'h00, "R8");
    step(3'd5, 8'h00, 11'h0, 1'b0, 5'h00, "R9");
    step(3'd5, 8'h00, 11'h0, 1'b0, 5'h00, "R9");

    // R7 interrupt pushes the current address, R6 return restores it; hold keeps the stack
    step(3'd3, 8'h00, 11'h345, 1'b1, 5'h08, "R4");
    step(3'd6, 8'h00, 11'h0, 1'b0, 5'h00, "R7");
    step(3'd0, 8'h00, 11'h0, 1'b0, 5'h00, "R11");
    step(3'd4, 8'h00, 11'h100, 1'b0, 5'h00, "R5");
    step(3'd5, 8'h00, 11'h0, 1'b0, 5'h00, "R5");
    step(3'd5, 8'h00, 11'h0, 1'b0, 5'h00, "R7");

    for (int i = 0; i < 3000; i++) begin
      step(3'($urandom % 8), 8'($urandom), 11'($urandom), ($urandom % 4) == 0,
           5'($urandom), "");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule